// File: doc/BRIEF.md
# Nested Priority-Group Interrupt Sequencer

This block sits on the processor side of the interrupt path. Each priority group has one level-sensitive request line and one acknowledge line. The lowest groups are external sources. The top group collects internal sources, and a cause index picks one of them. The block keeps an interrupt-enable bit and a current service level, and it checks requests only when the core reports an instruction boundary. When it accepts a request, the block pushes the return PC and the old level onto a small save stack. It then drops the enable bit, raises the level and issues a redirect pulse with a vector address. One cycle later it pulses the winning group's acknowledge so that the device can release its request.

A service routine can re-enable interrupts so that a higher group can nest over it. A return-from-interrupt pulse pops the most recent stack entry. That pop gives back the saved PC, restores the saved level and sets the enable bit again. The status word shows the enable bit at bit 9 and the current level in its low bits.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, status_o is 0 (enable clear, level 0), take_o, resume_o and ack_o are all 0, and the save stack is empty.
- R2: A request from group g is accepted only on a clock edge where insn_bound is high, the enable bit (status_o bit 9) is set and g+1 is greater than the current level. Level 0 means no routine is running.
- R3: When several eligible groups request in the same cycle, the highest-numbered group is accepted.
- R4: On the edge that accepts group g, take_o is high for one cycle with vec_o valid, the enable bit clears and the level (status_o bits 2:0) becomes g+1.
- R5: On the cycle after take_o, ack_o is one-hot at bit g for exactly one cycle. It is zero at all other times.
- R6: Vector addresses: an external group g (every group except the top one) maps to address g (0x000..0x002). The top group maps to 0x003 plus its cause, and any cause above 9 is clamped to 0x00C.
- R7: A group at or below the current level is not accepted. A higher group nests, and nesting reaches a depth equal to the number of groups.
- R8: A ret_pulse with a non-empty stack produces resume_o for one cycle and pops entries in last-in, first-out order. ret_pc_o gives the PC saved by the matching entry, the saved level is restored and the enable bit is set.
- R9: A ret_pulse while the stack is empty has no effect: there is no resume_o, and status_o does not change.
- R10: When ret_pulse (non-empty stack) and an acceptable request meet on the same boundary, only the return takes effect. The request is evaluated again at a later boundary against the restored level.
- R11: en_set sets and en_clr clears the enable bit, and en_clr wins when both are high. An acceptance in the same cycle clears the bit regardless of en_set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_GRP | Level request per priority group |
| cause_i | input | CAUSE_W | Internal source index for the top group |
| insn_bound | input | 1 | Instruction-boundary strobe |
| pc_i | input | PC_W | PC to resume at if interrupted now |
| ret_pulse | input | 1 | Return-from-interrupt pulse |
| en_set | input | 1 | Set enable bit |
| en_clr | input | 1 | Clear enable bit |
| take_o | output | 1 | Redirect pulse |
| vec_o | output | 12 | Vector address for the redirect |
| ack_o | output | NUM_GRP | One-cycle acknowledge per group |
| resume_o | output | 1 | Return pulse |
| ret_pc_o | output | PC_W | Restored PC with resume_o |
| status_o | output | PS_W | Status: bit 9 enable, low bits level |

## Verification
The risky overlap is a return pulse on the same instruction boundary as a pending request that the restored state would accept. The bench creates this case by re-enabling interrupts inside a service routine while a lower group still holds its request. It then issues the return together with the boundary strobe. The bench passes the design only if the scoreboard sees a single resume event with the saved PC and no redirect in that cycle, followed by the lower group's redirect and acknowledge at the next boundary. A second overlap, en_set in the same cycle as an acceptance, is judged by checking that the enable bit reads clear afterwards.

// File: rtl/irq_nest_pkg.sv
// Shared constants and types for the nested interrupt sequencer.
// Assumes internal sources occupy a contiguous vector range starting at
// INT_VEC_BASE, directly above the external ones.
package irq_nest_pkg;
    localparam int VEC_W        = 12;
    localparam int INT_VEC_BASE = 3;
    typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_grp_pick.sv
// Priority picker: chooses the highest-numbered requesting group, reports
// whether it outranks the running level, and forms its vector address.
// Assumes NUM_GRP-1 <= INT_VEC_BASE so external vectors do not overlap.
module irq_grp_pick
    import irq_nest_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int NUM_INT = 10,
    parameter int CAUSE_W = 4,
    localparam int GW     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int LVL_W  = $clog2(NUM_GRP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] req,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [LVL_W-1:0]   cur_lvl,
    output logic               hit,
    output logic [GW-1:0]      win_grp,
    output logic [LVL_W-1:0]   win_lvl,
    output vec_t               vec
);
    logic any_req;

    // Priority encode: later (higher) indices overwrite earlier ones.
    always_comb begin
        win_grp = '0;
        any_req = 1'b0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (req[g]) begin
                win_grp = GW'(g);
                any_req = 1'b1;
            end
        end
    end

    // Level of the winner and whether it may pre-empt the running level.
    always_comb begin
        win_lvl = LVL_W'(win_grp) + LVL_W'(1);
        hit     = any_req && (win_lvl > cur_lvl);
    end

    // Vector: external groups map to their index, top group to base+cause.
    always_comb begin
        if (win_grp == GW'(NUM_GRP - 1)) begin
            if (int'(cause) > NUM_INT - 1)
                vec = vec_t'(INT_VEC_BASE + NUM_INT - 1);
            else
                vec = vec_t'(INT_VEC_BASE) + vec_t'(cause);
        end else begin
            vec = vec_t'(win_grp);
        end
    end

    // R3: the winner requests and no higher-numbered group does.
    p_top_winner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (req[win_grp] && ((req >> win_grp) == NUM_GRP'(1))));

    // R6: every produced vector stays inside the defined vector space.
    p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (int'(vec) <= INT_VEC_BASE + NUM_INT - 1));
endmodule

// File: rtl/irq_save_stack.sv
// Return-state stack: one entry per nesting depth holding return PC and
// previous level. Assumes the caller never pushes and pops in one cycle.
module irq_save_stack #(
    parameter int DEPTH = 4,
    parameter int PC_W  = 16,
    parameter int LVL_W = 3,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [PC_W-1:0]  push_pc,
    input  logic [LVL_W-1:0] push_lvl,
    output logic [PC_W-1:0]  top_pc,
    output logic [LVL_W-1:0] top_lvl,
    output logic             empty,
    output logic             full
);
    logic [SP_W-1:0]  sp_q;
    logic [PC_W-1:0]  pc_mem  [DEPTH];
    logic [LVL_W-1:0] lvl_mem [DEPTH];

    assign empty = (sp_q == '0);
    assign full  = (sp_q == SP_W'(DEPTH));

    // Stack pointer: counts saved entries.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp_q <= '0;
        else if (push) sp_q <= sp_q + SP_W'(1);
        else if (pop)  sp_q <= sp_q - SP_W'(1);
    end

    // One register pair per slot, written when the pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_mem[i]  <= '0;
                lvl_mem[i] <= '0;
            end else if (push && sp_q == SP_W'(i)) begin
                pc_mem[i]  <= push_pc;
                lvl_mem[i] <= push_lvl;
            end
        end
    end

    // Top-of-stack read mux.
    always_comb begin
        top_pc  = '0;
        top_lvl = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp_q == SP_W'(i + 1)) begin
                top_pc  = pc_mem[i];
                top_lvl = lvl_mem[i];
            end
        end
    end

    // R7: nesting never exceeds the slot count.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R9: a pop is only issued with something saved.
    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/irq_nest_ctrl.sv
// Nested interrupt sequencer top. Samples level requests at instruction
// boundaries, saves return state, redirects to a vector, acknowledges the
// winner a cycle later and restores state on return. Assumes ret_pulse
// and insn_bound are single-cycle strobes from the core.
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int NUM_INT = 10,
    parameter int CAUSE_W = 4,
    parameter int PC_W    = 16,
    parameter int PS_W    = 16,
    parameter int IE_POS  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_GRP-1:0] req_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               insn_bound,
    input  logic [PC_W-1:0]    pc_i,
    input  logic               ret_pulse,
    input  logic               en_set,
    input  logic               en_clr,
    output logic               take_o,
    output logic [11:0]        vec_o,
    output logic [NUM_GRP-1:0] ack_o,
    output logic               resume_o,
    output logic [PC_W-1:0]    ret_pc_o,
    output logic [PS_W-1:0]    status_o
);
    localparam int GW    = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int LVL_W = $clog2(NUM_GRP + 1);

    logic               ie_q;
    logic [LVL_W-1:0]   lvl_q;
    logic               hit;
    logic [GW-1:0]      win_grp;
    logic [LVL_W-1:0]   win_lvl;
    vec_t               win_vec;
    logic               stk_empty, stk_full;
    logic [PC_W-1:0]    top_pc;
    logic [LVL_W-1:0]   top_lvl;
    logic               pop_c, take_c;
    logic [NUM_GRP-1:0] pend_q;
    vec_t               vec_q;

    irq_grp_pick #(.NUM_GRP(NUM_GRP), .NUM_INT(NUM_INT), .CAUSE_W(CAUSE_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(req_i), .cause(cause_i), .cur_lvl(lvl_q),
        .hit(hit), .win_grp(win_grp), .win_lvl(win_lvl), .vec(win_vec)
    );

    irq_save_stack #(.DEPTH(NUM_GRP), .PC_W(PC_W), .LVL_W(LVL_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take_c), .pop(pop_c),
        .push_pc(pc_i), .push_lvl(lvl_q),
        .top_pc(top_pc), .top_lvl(top_lvl), .empty(stk_empty), .full(stk_full)
    );

    // Accept/return decision: a return on the same boundary wins.
    always_comb begin
        pop_c  = ret_pulse && !stk_empty;
        take_c = insn_bound && ie_q && hit && !pop_c;
    end

    // Event outputs: redirect, deferred acknowledge and resume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o   <= 1'b0;
            vec_q    <= '0;
            pend_q   <= '0;
            ack_o    <= '0;
            resume_o <= 1'b0;
            ret_pc_o <= '0;
        end else begin
            take_o   <= take_c;
            pend_q   <= take_c ? (NUM_GRP'(1) << win_grp) : '0;
            ack_o    <= pend_q;
            resume_o <= pop_c;
            if (take_c) vec_q    <= win_vec;
            if (pop_c)  ret_pc_o <= top_pc;
        end
    end

    // Processor-status state: enable bit and running level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            lvl_q <= '0;
        end else if (take_c) begin
            ie_q  <= 1'b0;
            lvl_q <= win_lvl;
        end else if (pop_c) begin
            ie_q  <= 1'b1;
            lvl_q <= top_lvl;
        end else if (en_clr) begin
            ie_q  <= 1'b0;
        end else if (en_set) begin
            ie_q  <= 1'b1;
        end
    end

    // Status word assembly.
    always_comb begin
        status_o                = '0;
        status_o[IE_POS]        = ie_q;
        status_o[LVL_W-1:0]     = lvl_q;
        vec_o                   = vec_q;
    end

    // R2: a redirect only follows an enabled boundary.
    p_take_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($past(ie_q) && $past(insn_bound)));

    // R4: entering a routine leaves interrupts disabled.
    p_ie_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !ie_q);

    // R5: acknowledge follows a redirect and is one-hot.
    p_ack_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> ($countones(ack_o) == 1));

    // R5: acknowledge lasts one cycle.
    p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0) |=> (ack_o == '0));

    // R7: acceptance raises the level.
    p_lvl_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (lvl_q > $past(lvl_q)));

    // R8: a return re-enables interrupts.
    p_resume_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> ie_q);

    // R10: a valid return suppresses acceptance on that edge.
    p_ret_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_pulse && !stk_empty) |=> !take_o);
endmodule

// File: tb/tb_irq_nest_ctrl.sv
// Scoreboard bench: stimulus tasks queue expected events, a monitor pops
// and compares them against the observed redirect, acknowledge and resume.
module tb_irq_nest_ctrl;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [3:0]  cause_i = '0;
    logic        insn_bound = 1'b0;
    logic [15:0] pc_i = '0;
    logic        ret_pulse = 1'b0;
    logic        en_set = 1'b0;
    logic        en_clr = 1'b0;
    logic        take_o;
    logic [11:0] vec_o;
    logic [N-1:0] ack_o;
    logic        resume_o;
    logic [15:0] ret_pc_o;
    logic [15:0] status_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [19:0] exp_q [$];

    always #4 clk = ~clk;

    irq_nest_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .cause_i(cause_i),
        .insn_bound(insn_bound), .pc_i(pc_i), .ret_pulse(ret_pulse),
        .en_set(en_set), .en_clr(en_clr), .take_o(take_o), .vec_o(vec_o),
        .ack_o(ack_o), .resume_o(resume_o), .ret_pc_o(ret_pc_o), .status_o(status_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_ps(input bit ie, input int lvl, input string tag);
        int e;
        e = (int'(ie) << 9) | lvl;
        chk(int'(status_o) == e, tag, int'(status_o), e);
    endtask

    // Driver: one clock of stimulus; strobes are released after the edge.
    task automatic cyc(input logic b, input logic [15:0] pc, input logic rt,
                       input logic es, input logic ec);
        @(negedge clk);
        insn_bound = b; pc_i = pc; ret_pulse = rt; en_set = es; en_clr = ec;
        @(posedge clk);
        #1;
        insn_bound = 0; ret_pulse = 0; en_set = 0; en_clr = 0;
    endtask

    task automatic expect_take(input int vec, input int grp);
        exp_q.push_back({4'd1, 16'(vec)});
        exp_q.push_back({4'd2, 16'(1 << grp)});
    endtask

    task automatic expect_ret(input logic [15:0] pc);
        exp_q.push_back({4'd3, pc});
    endtask

    task automatic pop_cmp(input logic [3:0] kind, input logic [15:0] val);
        logic [19:0] it;
        string tag;
        tag = (kind == 4'd1) ? "R4 R6 take" : (kind == 4'd2) ? "R5 ack" : "R8 resume";
        if (exp_q.size() == 0) begin
            chk(0, {tag, " unexpected"}, int'(val), 0);
        end else begin
            it = exp_q.pop_front();
            chk(it == {kind, val}, tag, int'({kind, val}), int'(it));
        end
    endtask

    // Monitor: samples registered events between edges.
    always begin
        @(posedge clk);
        #2;
        if (rst_n && !done) begin
            if (take_o)        pop_cmp(4'd1, 16'(vec_o));
            if (ack_o != '0)   pop_cmp(4'd2, 16'(ack_o));
            if (resume_o)      pop_cmp(4'd3, ret_pc_o);
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk_ps(0, 0, "R1 status");
        chk(!take_o && !resume_o && ack_o == '0, "R1 events", int'(take_o), 0);
        @(negedge clk) rst_n = 1;

        // R2: disabled, then no strobe.
        req_i = 4'b0010;
        cyc(1, 16'h1000, 0, 0, 0);
        chk(!take_o, "R2 disabled", int'(take_o), 0);
        chk_ps(0, 0, "R2 status");
        cyc(0, 0, 0, 1, 0);
        chk_ps(1, 0, "R11 set");
        cyc(0, 16'h1000, 0, 0, 0);
        chk(!take_o, "R2 no strobe", int'(take_o), 0);

        // R4/R5: accept group 1.
        expect_take(1, 1);
        cyc(1, 16'h1000, 0, 0, 0);
        chk(take_o, "R4 take", int'(take_o), 1);
        chk_ps(0, 2, "R4 status");
        cyc(0, 0, 0, 0, 0);
        chk(ack_o == 4'b0010 && !take_o, "R5 ack", int'(ack_o), 2);
        cyc(0, 0, 0, 0, 0);
        chk(ack_o == 4'b0000, "R5 ack drop", int'(ack_o), 0);
        req_i = 4'b0000;

        // R7: lower and equal groups blocked, higher nests.
        cyc(0, 0, 0, 1, 0);
        req_i = 4'b0011;
        cyc(1, 16'h1111, 0, 0, 0);
        chk(!take_o, "R7 blocked", int'(take_o), 0);
        chk_ps(1, 2, "R7 status");
        req_i = 4'b0101;
        expect_take(2, 2);
        cyc(1, 16'h2000, 0, 0, 0);
        chk_ps(0, 3, "R7 nest");
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        req_i = 4'b0001;
        cyc(0, 0, 0, 1, 0);
        req_i = 4'b1001; cause_i = 4'd5;
        expect_take(8, 3);
        cyc(1, 16'h3000, 0, 0, 0);
        chk(vec_o == 12'h008, "R6 internal", int'(vec_o), 8);
        chk_ps(0, 4, "R7 depth");
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        req_i = 4'b0001;

        // R8: unwind in LIFO order.
        expect_ret(16'h3000);
        cyc(0, 0, 1, 0, 0);
        chk_ps(1, 3, "R8 pop1");
        expect_ret(16'h2000);
        cyc(0, 0, 1, 0, 0);
        chk_ps(1, 2, "R8 pop2");
        expect_ret(16'h1000);
        cyc(0, 0, 1, 0, 0);
        chk_ps(1, 0, "R8 pop3");
        cyc(0, 0, 1, 0, 0);
        chk(!resume_o, "R9 empty", int'(resume_o), 0);
        chk_ps(1, 0, "R9 status");

        // R3: simultaneous requests.
        req_i = 4'b0101;
        expect_take(2, 2);
        cyc(1, 16'h4000, 0, 0, 0);
        chk(vec_o == 12'h002, "R3 winner", int'(vec_o), 2);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        req_i = 4'b0001;
        cyc(0, 0, 0, 1, 0);

        // R10: return and request on one boundary.
        expect_ret(16'h4000);
        cyc(1, 16'h4100, 1, 0, 0);
        chk(!take_o, "R10 no take", int'(take_o), 0);
        chk_ps(1, 0, "R10 status");
        expect_take(0, 0);
        cyc(1, 16'h4200, 0, 0, 0);
        chk(vec_o == 12'h000, "R10 later take", int'(vec_o), 0);
        chk_ps(0, 1, "R10 level");
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        req_i = 4'b0000;
        expect_ret(16'h4200);
        cyc(0, 0, 1, 0, 0);

        // R6: cause clamp.
        req_i = 4'b1000; cause_i = 4'd15;
        expect_take(12, 3);
        cyc(1, 16'h5000, 0, 0, 0);
        chk(vec_o == 12'h00C, "R6 clamp", int'(vec_o), 12);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        req_i = 4'b0000;
        expect_ret(16'h5000);
        cyc(0, 0, 1, 0, 0);
        chk_ps(1, 0, "R8 restore");

        // R11: clear beats set; acceptance beats set.
        cyc(0, 0, 0, 1, 1);
        chk_ps(0, 0, "R11 clr wins");
        cyc(0, 0, 0, 1, 0);
        req_i = 4'b0010;
        expect_take(1, 1);
        cyc(1, 16'h6000, 0, 1, 0);
        chk_ps(0, 2, "R11 take wins");
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        req_i = 4'b0000;
        expect_ret(16'h6000);
        cyc(0, 0, 1, 0, 0);
        repeat (3) cyc(0, 0, 0, 0, 0);
        chk(exp_q.size() == 0, "R5 R8 leftover events", exp_q.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule